// File: doc/BRIEF.md
# Ordering-Selectable Store Buffer

This block sits between the load/store pipeline of one core and a single memory port. Stores are parked in a small buffer. Loads go to memory or are answered from the buffer. A two-bit mode input selects which ordering rules between memory operations are enforced:

- Sequential: every ordering is kept.
- Store-order: a load may pass older stores.
- Partial-store: stores to different addresses may also drain out of order.
- Relaxed: everything may reorder except same-location pairs.

Stores are written back lazily. A store leaves the buffer only when the buffer is full, when a flush is pending, or when a sequential-mode load is waiting for the buffer to empty. Only then does buffering have a visible effect on the order seen at the port. A buffered store stays invisible at the memory port until it drains. The core sees one request interface with a ready signal and gets a load response exactly one cycle after its load is accepted.

Top module: `order_store_buf`

## Requirements
- R1: After reset the buffer is empty, `drained` is high, no memory request is made, no response is given, and a store request sees `req_ready` high.
- R2: In mode 0 (sequential), memory operations reach the port in program order. A load is issued to memory only when the buffer is empty, and its request causes buffered stores to drain. Loads are never forwarded in this mode.
- R3: In mode 1 (store-order), a load that misses the buffer goes to memory immediately, ahead of buffered stores, and stores drain strictly oldest first.
- R4: In modes 2 and 3 (partial-store and relaxed), a new store takes the lowest-numbered free slot. Each drain picks the lowest-numbered slot that has no older valid entry to the same address.
- R5: In every mode, a load returns the value of the latest earlier store to its address in program order, and stores to one address reach memory in program order.
- R6: In modes 1 to 3, a load whose address matches a buffered store is answered from the youngest matching entry and makes no memory request.
- R7: The buffer holds at most 4 stores, and `req_ready` is low for a store while all 4 are occupied.
- R8: A one-cycle `flush` pulse with a non-empty buffer drains all stores. New stores are stalled until the buffer is empty. `drained` is high exactly when the buffer is empty, and no store is written while it is high.
- R9: The memory port carries at most one operation per cycle (`mem_we` 1 = store, 0 = load). An accepted load gives `rsp_valid` for exactly the following cycle, and memory read data arrives on `mem_rdata` in that cycle.
- R10: Mode encoding: 0 sequential, 1 store-order, 2 partial-store, 3 relaxed. The mode may be changed only while `drained` is high.
- R11: A buffered store is written to memory only while the buffer is full, a flush is pending, or a mode-0 load is waiting. In any other case it stays invisible at the port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Ordering rule set (0..3) |
| flush | input | 1 | Pulse to drain every buffered store |
| req_valid | input | 1 | Core request present |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | DW | Load response data |
| mem_valid | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 = write (drain), 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after a read |
| drained | output | 1 | Buffer empty |

## Verification
The bench drives the buffer until its slot numbers no longer follow program age. It then checks that the partial-store and relaxed modes drain a young store from a low slot first, while the store-order mode keeps age order. It also checks that a blocked same-address store is skipped rather than overtaken. A wrong selector would write a stale value over a newer one or empty the buffer in FIFO order.

Directed cases cover the following:
- A sequential-mode load must first push every store out.
- A store-order load must bypass the stores.
- A hit must forward the youngest of two matching entries.
- Stores must stall during a flush.

Random traffic in every mode compares each load against a program-order shadow, and compares memory after each flush. A design that forwarded an old entry, or let a load pass a matching store, would return a stale value there.

// File: rtl/order_store_buf.sv
module order_store_buf #(
  parameter int DEPTH = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          flush,
  input  logic          req_valid,
  input  logic          req_is_store,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          drained
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld;
  logic [AW-1:0]    addr_q  [DEPTH];
  logic [DW-1:0]    data_q  [DEPTH];
  logic [DEPTH-1:0] older_q [DEPTH];
  logic             flushing_q, rsp_valid_q, rsp_fwd_q;
  logic [DW-1:0]    fwd_q;

  logic [DEPTH-1:0] hit, elig, dmask;
  logic [DW-1:0]    fwd_d;
  logic [IW-1:0]    didx, fidx;
  logic             have_d;

  wire relaxed  = (mode != 2'd0);
  wire slot_ord = mode[1];
  wire empty    = ~|vld;
  wire full     = &vld;
  wire is_ld    = req_valid & ~req_is_store;
  wire is_st    = req_valid & req_is_store;

  always_comb begin
    logic blocked, oldest, yh;
    hit = '0; elig = '0; fwd_d = '0; didx = '0; fidx = '0; have_d = 1'b0;
    blocked = 1'b0; oldest = 1'b0; yh = 1'b0;
    for (int i = 0; i < DEPTH; i++) hit[i] = vld[i] && (addr_q[i] == req_addr);
    for (int i = 0; i < DEPTH; i++) begin
      blocked = 1'b0;
      oldest  = vld[i];
      for (int j = 0; j < DEPTH; j++)
        if (vld[j] && older_q[i][j]) begin
          oldest = 1'b0;
          if (addr_q[j] == addr_q[i]) blocked = 1'b1;
        end
      elig[i] = slot_ord ? (vld[i] && !blocked) : oldest;
    end
    for (int i = 0; i < DEPTH; i++) begin
      yh = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (hit[j] && older_q[j][i]) yh = 1'b1;
      if (hit[i] && !yh) fwd_d = data_q[i];
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin have_d = 1'b1; didx = IW'(i); end
      if (!vld[i]) fidx = IW'(i);
    end
  end

  wire load_fwd   = is_ld & relaxed & (|hit);
  wire load_mem   = is_ld & (relaxed ? ~(|hit) : empty);
  wire want_drain = ~empty & (full | flushing_q | (is_ld & ~relaxed));
  wire do_drain   = want_drain & ~load_mem & have_d;
  wire st_ok      = is_st & ~full & ~flushing_q;

  assign dmask     = do_drain ? (DEPTH'(1) << didx) : '0;
  assign req_ready = req_is_store ? (~full & ~flushing_q) : (relaxed | empty);
  assign mem_valid = load_mem | do_drain;
  assign mem_we    = ~load_mem;
  assign mem_addr  = load_mem ? req_addr : addr_q[didx];
  assign mem_wdata = data_q[didx];
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_fwd_q ? fwd_q : mem_rdata;
  assign drained   = empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      flushing_q <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_fwd_q <= 1'b0;
      fwd_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        older_q[i] <= '0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      rsp_valid_q <= load_fwd | load_mem;
      rsp_fwd_q   <= load_fwd;
      if (load_fwd) fwd_q <= fwd_d;
      if (flush && !empty) flushing_q <= 1'b1;
      else if (empty) flushing_q <= 1'b0;
      if (do_drain) vld[didx] <= 1'b0;
      if (st_ok) begin
        vld[fidx]     <= 1'b1;
        addr_q[fidx]  <= req_addr;
        data_q[fidx]  <= req_wdata;
        older_q[fidx] <= vld & ~dmask;
        for (int i = 0; i < DEPTH; i++)
          if (IW'(i) != fidx) older_q[i][fidx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/order_store_buf_chk.sv
module order_store_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       req_valid,
  input logic       req_is_store,
  input logic       req_ready,
  input logic       mem_valid,
  input logic       mem_we,
  input logic       rsp_valid,
  input logic       drained,
  input logic       full,
  input logic       empty,
  input logic       flushing_q,
  input logic       load_fwd
);
  AST_SC_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd0 && mem_valid && !mem_we) |-> empty); // R2
  AST_FWD_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n) load_fwd |-> !(mem_valid && !mem_we)); // R6
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_is_store && req_ready) |=> rsp_valid); // R9
  AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(req_valid && !req_is_store && req_ready)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) full |-> !(req_valid && req_is_store && req_ready)); // R7
  AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n) flushing_q |-> !(req_is_store && req_ready)); // R8
  AST_LAZY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && mem_we) |-> (full || flushing_q || (mode == 2'd0 && req_valid && !req_is_store))); // R11
  AST_IDLE_WHEN_DRAINED: assert property (@(posedge clk) disable iff (!rst_n) drained |-> !(mem_valid && mem_we)); // R8
endmodule

bind order_store_buf order_store_buf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid), .req_is_store(req_is_store),
  .req_ready(req_ready), .mem_valid(mem_valid), .mem_we(mem_we), .rsp_valid(rsp_valid),
  .drained(drained), .full(full), .empty(empty), .flushing_q(flushing_q), .load_fwd(load_fwd)
);

// File: tb/sim_order_store_buf.sv
`timescale 1ns/1ps
module sim_order_store_buf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic flush = 1'b0, req_valid = 1'b0, req_is_store = 1'b1;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_valid, mem_we, drained;
  logic [7:0] rsp_data, mem_wdata, mem_rdata;
  logic [3:0] mem_addr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] memv [16];
  logic [7:0] shadow [16];
  bit tr_we [64];
  logic [3:0] tr_a [64];
  logic [7:0] tr_d [64];
  int tr_n = 0;

  order_store_buf u0 (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) memv[i] <= 8'(i * 7 + 1);
      mem_rdata <= '0;
    end else if (mem_valid) begin
      if (mem_we) memv[mem_addr] <= mem_wdata;
      else mem_rdata <= memv[mem_addr];
    end
  end

  initial forever begin
    @(negedge clk); #5;
    if (rst_n && mem_valid && tr_n < 64) begin
      tr_we[tr_n] = mem_we; tr_a[tr_n] = mem_addr; tr_d[tr_n] = mem_wdata; tr_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic op(input bit st, input logic [3:0] a, input logic [7:0] d,
                    output logic [7:0] got, output bit gotv);
    @(negedge clk);
    req_valid = 1'b1; req_is_store = st; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0; req_is_store = 1'b1;
    #1;
    gotv = rsp_valid; got = rsp_data;
  endtask

  task automatic do_flush(input bit expect_stall);
    @(negedge clk); flush = 1'b1; req_is_store = 1'b1;
    @(negedge clk); flush = 1'b0; #1;
    if (expect_stall) chk(req_ready == 1'b0, "R8 store stalled during flush", req_ready, 0);
    while (!drained) begin @(negedge clk); #1; end
  endtask

  task automatic set_mode(input logic [1:0] m);
    do_flush(1'b0);
    mode = m;
  endtask

  task automatic check_trace(input string tag, input logic [3:0] ea [5], input logic [7:0] ed [5]);
    chk(tr_n == 5, {tag, " trace length"}, tr_n, 5);
    for (int i = 0; i < 5; i++) begin
      chk(tr_we[i] && tr_a[i] == ea[i], {tag, " drain address"}, tr_a[i], ea[i]);
      chk(tr_d[i] == ed[i], {tag, " drain data"}, tr_d[i], ed[i]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] g;
    bit gv;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(drained == 1'b1, "R1 drained after reset", drained, 1);
    chk(mem_valid == 1'b0, "R1 no memory request", mem_valid, 0);
    chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
    chk(req_ready == 1'b1, "R1 store ready", req_ready, 1);

    // R10 mode 0 sequential: load waits, drains stores first, no forwarding
    mode = 2'd0; tr_n = 0;
    op(1, 4'd3, 8'd44, g, gv);
    op(1, 4'd4, 8'd55, g, gv);
    chk(tr_n == 0, "R11 stores held while not forced", tr_n, 0);
    op(0, 4'd3, 8'd0, g, gv);
    chk(gv && g == 8'd44, "R2 R5 sequential load value", g, 44);
    chk(tr_n == 3 && tr_we[0] && tr_a[0] == 4'd3 && tr_we[1] && tr_a[1] == 4'd4,
        "R2 stores precede load", tr_n, 3);
    chk(!tr_we[2] && tr_a[2] == 4'd3, "R2 R10 load reached memory last", tr_a[2], 3);

    // mode 1 store-order: bypass and forwarding
    set_mode(2'd1); tr_n = 0;
    op(1, 4'd1, 8'd11, g, gv);
    op(1, 4'd2, 8'd22, g, gv);
    op(1, 4'd1, 8'd33, g, gv);
    op(0, 4'd5, 8'd0, g, gv);
    chk(tr_n == 1 && !tr_we[0] && tr_a[0] == 4'd5, "R3 load bypasses buffered stores", tr_n, 1);
    chk(gv && g == 8'(5 * 7 + 1), "R9 bypass load data", g, 5 * 7 + 1);
    op(0, 4'd1, 8'd0, g, gv);
    chk(gv && g == 8'd33, "R6 youngest entry forwarded", g, 33);
    chk(tr_n == 1, "R6 forwarded load makes no request", tr_n, 1);
    do_flush(1'b1);
    chk(drained == 1'b1, "R8 drained after flush", drained, 1);
    chk(tr_n == 4 && tr_a[1] == 4'd1 && tr_d[1] == 8'd11 && tr_a[2] == 4'd2 && tr_a[3] == 4'd1 && tr_d[3] == 8'd33,
        "R3 stores drained oldest first", tr_n, 4);
    chk(memv[1] == 8'd33, "R5 final value at same address", memv[1], 33);

    // store-order with five stores: age order kept
    tr_n = 0;
    for (int i = 0; i < 5; i++) op(1, 4'(8 + i), 8'(100 + i), g, gv);
    do_flush(1'b0);
    check_trace("R3 age order", '{4'd8, 4'd9, 4'd10, 4'd11, 4'd12},
                '{8'd100, 8'd101, 8'd102, 8'd103, 8'd104});

    // mode 2 partial-store: slot order after reuse
    set_mode(2'd2); tr_n = 0;
    for (int i = 0; i < 4; i++) op(1, 4'(8 + i), 8'(100 + i), g, gv);
    chk(req_ready == 1'b0, "R7 store stalled when full", req_ready, 0);
    op(1, 4'd12, 8'd104, g, gv);
    do_flush(1'b0);
    check_trace("R4 slot order", '{4'd8, 4'd12, 4'd9, 4'd10, 4'd11},
                '{8'd100, 8'd104, 8'd101, 8'd102, 8'd103});

    // mode 3 relaxed: same-address store in low slot is held back
    set_mode(2'd3); tr_n = 0;
    for (int i = 0; i < 4; i++) op(1, 4'(8 + i), 8'(100 + i), g, gv);
    op(1, 4'd10, 8'd150, g, gv);
    op(0, 4'd10, 8'd0, g, gv);
    chk(gv && g == 8'd150, "R6 relaxed forward youngest", g, 150);
    do_flush(1'b0);
    check_trace("R4 R5 same address held", '{4'd8, 4'd9, 4'd10, 4'd10, 4'd11},
                '{8'd100, 8'd101, 8'd102, 8'd150, 8'd103});

    // random traffic in every mode against a program-order shadow
    for (int ph = 0; ph < 8; ph++) begin
      set_mode(2'(ph % 4));
      for (int i = 0; i < 16; i++) shadow[i] = memv[i];
      for (int k = 0; k < 120; k++) begin
        bit st;
        logic [3:0] a;
        logic [7:0] d;
        st = 1'($urandom % 2); a = 4'($urandom % 6); d = 8'($urandom);
        op(st, a, d, g, gv);
        if (st) shadow[a] = d;
        else chk(gv && g == shadow[a], "R5 R9 random load value", g, shadow[a]);
      end
      do_flush(1'b0);
      for (int i = 0; i < 16; i++) chk(memv[i] == shadow[i], "R5 memory after flush", memv[i], shadow[i]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule